// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out the architectural state changes a processor core makes when it enters a trap handler. The core hands it one trap request on a valid/ready channel. The request carries the trap class (0 to 8), a trap identification number, the program counter of the trapping instruction and of the instruction after it, and the current values of the status word, interrupt control, previous-context link, stack pointer, system control, interrupt stack pointer, trap vector base and interrupt vector base. The block works out the new status word, interrupt control, previous-context link, stack pointer, return address, identification value, system control and fetch address.

Most classes need the upper register context saved before entry. For those, the block raises a save request to an external context-save unit and holds it until that unit acknowledges. All results commit on a single clock edge. A one-cycle done strobe then follows, and the results stay on the outputs until the next commit.

Back-pressure rules: `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and all request fields are captured at that edge. `req_ready` stays low from that edge until the cycle after `done`. While the channel is not ready, `req_valid` is ignored.

Top module: `trap_entry_seq`

## Requirements
- R1: On a legal class, if status bit 9 (interrupt-stack in use) is 0 on entry, `new_sp` becomes `int_sp`; otherwise `new_sp` keeps `cur_sp`. In both cases `new_stat[9]` is 1.
- R2: On a legal class, `new_stat[11:10]` (I/O privilege) becomes 2'b10 (supervisor) and `new_stat[13:12]` (protection set) becomes 0.
- R3: On a legal class, `new_stat[6:0]` (call depth count) becomes 0, `new_stat[7]` (depth count enable) becomes 1 and `new_stat[8]` (global register write enable) becomes 0. Status bits 31:14 are kept.
- R4: On a legal class, `new_prev_ctx[23]` takes `cur_irq_ctl[8]` (interrupt enable), `new_prev_ctx[31:24]` takes `cur_irq_ctl[7:0]` (current priority) and `new_prev_ctx[22:0]` is kept. `new_irq_ctl` equals `cur_irq_ctl` with bit 8 cleared.
- R5: For classes 0 to 7, `new_pc` = `trap_base | (class << 5)`.
- R6: For class 8 (external interrupt), `new_pc` = `irq_base | ((cur_irq_ctl & 32'h00FF0000) >> 10)`.
- R7: On a legal class, `id_out` is the trap identification number, zero-extended.
- R8: `ret_addr` is `req_pc`, except for class 6 (system call), where it is `req_next_pc`.
- R9: For class 3 with identification 4 (free context list depleted), `new_sys_ctl` is `cur_sys_ctl` with bit 0 set, and `ret_addr` is `trap_base | 32'h60`. For every other legal request, `new_sys_ctl` equals `cur_sys_ctl`.
- R10: After a request is taken, `save_req` goes high and stays high until `save_ack` is seen, except for class 6, class 3 with identification 5 (free list underflow) and classes above 8. Results commit on the edge where `save_ack` is seen, or on the first edge after acceptance when no save is needed.
- R11: For a class above 8, no save is requested, `new_pc` becomes `req_pc`, `err` becomes 1, and every other result output keeps its previous value. A legal commit clears `err`.
- R12: `done` is high for exactly one cycle, in the cycle after the commit edge. `req_ready` is low from acceptance through the `done` cycle. After reset, `req_ready` is 1, `done`, `err` and `save_req` are 0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Trap request valid |
| req_ready | output | 1 | Sequencer idle, accepting a request |
| req_class | input | CLS_W | Trap class |
| req_tin | input | TIN_W | Trap identification number |
| req_pc | input | XLEN | PC of the trapping instruction |
| req_next_pc | input | XLEN | PC of the following instruction |
| cur_stat | input | XLEN | Current status word |
| cur_irq_ctl | input | XLEN | Current interrupt control word |
| cur_prev_ctx | input | XLEN | Current previous-context link |
| cur_sp | input | XLEN | Current stack pointer |
| cur_sys_ctl | input | XLEN | Current system control word |
| int_sp | input | XLEN | Interrupt stack pointer |
| trap_base | input | XLEN | Trap vector base |
| irq_base | input | XLEN | Interrupt vector base |
| save_req | output | 1 | Upper-context save request |
| save_ack | input | 1 | Upper-context save complete |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Last request had an illegal class |
| new_pc | output | XLEN | Next fetch address |
| ret_addr | output | XLEN | Return address |
| id_out | output | XLEN | Identification value for the handler |
| new_sp | output | XLEN | New stack pointer |
| new_stat | output | XLEN | New status word |
| new_irq_ctl | output | XLEN | New interrupt control word |
| new_prev_ctx | output | XLEN | New previous-context link |
| new_sys_ctl | output | XLEN | New system control word |

## Verification
The bench targets the cases where one class or identification changes the rules.

- The system call must return to the next instruction and skip the save. A design that merged it with the other classes would return to the trapping instruction and stall on a save request.
- A depleted free list must set the system-control flag and return to its own vector. A design that missed this case would return to the faulting PC.
- Underflow must skip the save. A design that missed it would hang waiting on an acknowledge.
- The interrupt class must vector from the pending-priority field rather than the class number.
- The stack switch must happen only when status bit 9 is clear, or the current stack is lost.
- An illegal class must leave the earlier results untouched.
- A delayed acknowledge must not commit early, and `done` must not last longer than one cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // status word fields
  localparam int ST_CDC_LSB = 0;
  localparam int ST_CDC_W   = 7;
  localparam int ST_CDE     = 7;
  localparam int ST_GW      = 8;
  localparam int ST_IS      = 9;
  localparam int ST_IO_LSB  = 10;
  localparam int ST_PRS_LSB = 12;
  localparam logic [1:0] IO_SUPER = 2'b10;
  // interrupt control fields
  localparam int IC_CPN_LSB  = 0;
  localparam int IC_PRIO_W   = 8;
  localparam int IC_IE       = 8;
  localparam int IC_PEND_LSB = 16;
  // previous-context link fields
  localparam int PX_PIE     = 23;
  localparam int PX_CPN_LSB = 24;
  // system control flag
  localparam int SC_DEPL = 0;
  // vector arithmetic
  localparam int VEC_SHIFT  = 5;
  localparam int PEND_SHIFT = 10;
  // class and identification codes
  localparam int CLS_CTX     = 3;
  localparam int CLS_SYSCALL = 6;
  localparam int CLS_IRQ     = 8;
  localparam int TIN_DEPLETED  = 4;
  localparam int TIN_UNDERFLOW = 5;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} seq_state_t;
endpackage

// File: rtl/trap_status_rewrite.sv
module trap_status_rewrite
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur_stat,
  input  logic [XLEN-1:0] cur_sp,
  input  logic [XLEN-1:0] int_sp,
  output logic [XLEN-1:0] new_stat,
  output logic [XLEN-1:0] new_sp
);
  localparam int KEEP_LSB = ST_PRS_LSB + 2;

  always_comb begin
    new_sp = cur_stat[ST_IS] ? cur_sp : int_sp;
    new_stat = cur_stat;
    new_stat[ST_CDC_LSB +: ST_CDC_W] = '0;
    new_stat[ST_CDE]                 = 1'b1;
    new_stat[ST_GW]                  = 1'b0;
    new_stat[ST_IS]                  = 1'b1;
    new_stat[ST_IO_LSB +: 2]         = IO_SUPER;
    new_stat[ST_PRS_LSB +: 2]        = 2'b00;
  end

  // upper bits pass through one by one
  logic [XLEN-1:0] pass_chk;
  genvar gi;
  generate
    for (gi = 0; gi < XLEN; gi++) begin : g_pass
      if (gi >= KEEP_LSB) begin : g_keep
        assign pass_chk[gi] = (new_stat[gi] == cur_stat[gi]);
      end else begin : g_fld
        assign pass_chk[gi] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    a_r3_upper_kept: assert (&pass_chk);
  end
endmodule

// File: rtl/trap_ctx_link.sv
module trap_ctx_link
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur_irq_ctl,
  input  logic [XLEN-1:0] cur_prev_ctx,
  output logic [XLEN-1:0] new_irq_ctl,
  output logic [XLEN-1:0] new_prev_ctx
);
  always_comb begin
    new_prev_ctx = cur_prev_ctx;
    new_prev_ctx[PX_PIE] = cur_irq_ctl[IC_IE];
    new_prev_ctx[PX_CPN_LSB +: IC_PRIO_W] = cur_irq_ctl[IC_CPN_LSB +: IC_PRIO_W];
    new_irq_ctl = cur_irq_ctl;
    new_irq_ctl[IC_IE] = 1'b0;
  end
endmodule

// File: rtl/trap_target_sel.sv
module trap_target_sel
  import trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CLS_W = 4,
  parameter int TIN_W = 8
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [TIN_W-1:0] tin,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  next_pc,
  input  logic [XLEN-1:0]  trap_base,
  input  logic [XLEN-1:0]  irq_base,
  input  logic [XLEN-1:0]  cur_irq_ctl,
  input  logic [XLEN-1:0]  cur_sys_ctl,
  output logic [XLEN-1:0]  new_pc,
  output logic [XLEN-1:0]  ret_addr,
  output logic [XLEN-1:0]  id_val,
  output logic [XLEN-1:0]  new_sys_ctl,
  output logic             need_save,
  output logic             bad_class
);
  localparam logic [XLEN-1:0] PEND_MASK = XLEN'({IC_PRIO_W{1'b1}}) << IC_PEND_LSB;

  logic is_irq, is_sys, is_depl, is_unf;
  logic [XLEN-1:0] vec_trap, vec_irq;

  always_comb begin
    bad_class = (cls > CLS_W'(CLS_IRQ));
    is_irq    = (cls == CLS_W'(CLS_IRQ));
    is_sys    = (cls == CLS_W'(CLS_SYSCALL));
    is_depl   = (cls == CLS_W'(CLS_CTX)) && (tin == TIN_W'(TIN_DEPLETED));
    is_unf    = (cls == CLS_W'(CLS_CTX)) && (tin == TIN_W'(TIN_UNDERFLOW));
    vec_trap  = trap_base | (XLEN'(cls) << VEC_SHIFT);
    vec_irq   = irq_base | ((cur_irq_ctl & PEND_MASK) >> PEND_SHIFT);

    if (bad_class)   new_pc = pc;
    else if (is_irq) new_pc = vec_irq;
    else             new_pc = vec_trap;

    if (is_depl)     ret_addr = vec_trap;
    else if (is_sys) ret_addr = next_pc;
    else             ret_addr = pc;

    id_val = XLEN'(tin);
    new_sys_ctl = cur_sys_ctl;
    if (is_depl) new_sys_ctl[SC_DEPL] = 1'b1;

    need_save = !bad_class && !is_sys && !is_unf;
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CLS_W = 4,
  parameter int TIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CLS_W-1:0] req_class,
  input  logic [TIN_W-1:0] req_tin,
  input  logic [XLEN-1:0]  req_pc,
  input  logic [XLEN-1:0]  req_next_pc,
  input  logic [XLEN-1:0]  cur_stat,
  input  logic [XLEN-1:0]  cur_irq_ctl,
  input  logic [XLEN-1:0]  cur_prev_ctx,
  input  logic [XLEN-1:0]  cur_sp,
  input  logic [XLEN-1:0]  cur_sys_ctl,
  input  logic [XLEN-1:0]  int_sp,
  input  logic [XLEN-1:0]  trap_base,
  input  logic [XLEN-1:0]  irq_base,
  output logic             save_req,
  input  logic             save_ack,
  output logic             done,
  output logic             err,
  output logic [XLEN-1:0]  new_pc,
  output logic [XLEN-1:0]  ret_addr,
  output logic [XLEN-1:0]  id_out,
  output logic [XLEN-1:0]  new_sp,
  output logic [XLEN-1:0]  new_stat,
  output logic [XLEN-1:0]  new_irq_ctl,
  output logic [XLEN-1:0]  new_prev_ctx,
  output logic [XLEN-1:0]  new_sys_ctl
);
  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic [TIN_W-1:0] tin;
    logic [XLEN-1:0]  pc;
    logic [XLEN-1:0]  next_pc;
    logic [XLEN-1:0]  stat;
    logic [XLEN-1:0]  irq_ctl;
    logic [XLEN-1:0]  prev_ctx;
    logic [XLEN-1:0]  sp;
    logic [XLEN-1:0]  sys_ctl;
    logic [XLEN-1:0]  isp;
    logic [XLEN-1:0]  tbase;
    logic [XLEN-1:0]  ibase;
  } trap_req_t;

  seq_state_t state;
  trap_req_t  rq;

  logic [XLEN-1:0] c_stat, c_sp, c_irq_ctl, c_prev_ctx;
  logic [XLEN-1:0] c_pc, c_ret, c_id, c_sys_ctl;
  logic            c_need_save, c_bad;
  logic            commit;

  trap_status_rewrite #(.XLEN(XLEN)) u_stat (
    .cur_stat (rq.stat),
    .cur_sp   (rq.sp),
    .int_sp   (rq.isp),
    .new_stat (c_stat),
    .new_sp   (c_sp)
  );

  trap_ctx_link #(.XLEN(XLEN)) u_link (
    .cur_irq_ctl  (rq.irq_ctl),
    .cur_prev_ctx (rq.prev_ctx),
    .new_irq_ctl  (c_irq_ctl),
    .new_prev_ctx (c_prev_ctx)
  );

  trap_target_sel #(.XLEN(XLEN), .CLS_W(CLS_W), .TIN_W(TIN_W)) u_tgt (
    .cls         (rq.cls),
    .tin         (rq.tin),
    .pc          (rq.pc),
    .next_pc     (rq.next_pc),
    .trap_base   (rq.tbase),
    .irq_base    (rq.ibase),
    .cur_irq_ctl (rq.irq_ctl),
    .cur_sys_ctl (rq.sys_ctl),
    .new_pc      (c_pc),
    .ret_addr    (c_ret),
    .id_val      (c_id),
    .new_sys_ctl (c_sys_ctl),
    .need_save   (c_need_save),
    .bad_class   (c_bad)
  );

  assign req_ready = (state == S_IDLE);
  assign save_req  = (state == S_WAIT) && c_need_save;
  assign done      = (state == S_DONE);
  assign commit    = (state == S_WAIT) && (!c_need_save || save_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rq    <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          rq.cls     <= req_class;
          rq.tin     <= req_tin;
          rq.pc      <= req_pc;
          rq.next_pc <= req_next_pc;
          rq.stat    <= cur_stat;
          rq.irq_ctl <= cur_irq_ctl;
          rq.prev_ctx <= cur_prev_ctx;
          rq.sp      <= cur_sp;
          rq.sys_ctl <= cur_sys_ctl;
          rq.isp     <= int_sp;
          rq.tbase   <= trap_base;
          rq.ibase   <= irq_base;
          state      <= S_WAIT;
        end
        S_WAIT: if (commit) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err          <= 1'b0;
      new_pc       <= '0;
      ret_addr     <= '0;
      id_out       <= '0;
      new_sp       <= '0;
      new_stat     <= '0;
      new_irq_ctl  <= '0;
      new_prev_ctx <= '0;
      new_sys_ctl  <= '0;
    end else if (commit) begin
      new_pc <= c_pc;
      err    <= c_bad;
      if (!c_bad) begin
        ret_addr     <= c_ret;
        id_out       <= c_id;
        new_sp       <= c_sp;
        new_stat     <= c_stat;
        new_irq_ctl  <= c_irq_ctl;
        new_prev_ctx <= c_prev_ctx;
        new_sys_ctl  <= c_sys_ctl;
      end
    end
  end

  // R12: strobe is a single cycle
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12: channel closes after a handshake
  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10: request held until acknowledged
  a_r10_save_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !save_ack) |=> (save_req && !done));
  // R10: acknowledge leads to completion
  a_r10_ack_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && save_ack) |=> done);
  // R2: supervisor privilege on a legal entry
  a_r2_io_super: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (new_stat[ST_IO_LSB +: 2] == IO_SUPER));
  // R1: interrupt stack marked in use
  a_r1_stack_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> new_stat[ST_IS]);
  // R4: interrupts disabled on entry
  a_r4_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> !new_irq_ctl[IC_IE]);
  // R11: illegal class never asks for a save
  a_r11_no_save_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> $past(!save_req));
endmodule

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;
  localparam int XLEN = 32;
  localparam int CLS_W = 4;
  localparam int TIN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, save_ack = 0;
  logic [CLS_W-1:0] req_class = '0;
  logic [TIN_W-1:0] req_tin = '0;
  logic [XLEN-1:0] req_pc = '0, req_next_pc = '0, cur_stat = '0, cur_irq_ctl = '0;
  logic [XLEN-1:0] cur_prev_ctx = '0, cur_sp = '0, cur_sys_ctl = '0, int_sp = '0;
  logic [XLEN-1:0] trap_base = '0, irq_base = '0;
  logic req_ready, save_req, done, err;
  logic [XLEN-1:0] new_pc, ret_addr, id_out, new_sp, new_stat, new_irq_ctl, new_prev_ctx, new_sys_ctl;

  trap_entry_seq #(.XLEN(XLEN), .CLS_W(CLS_W), .TIN_W(TIN_W)) dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // expected state of result outputs
  logic [XLEN-1:0] e_pc = 0, e_ret = 0, e_id = 0, e_sp = 0, e_stat = 0, e_ic = 0, e_px = 0, e_sc = 0;
  logic e_err = 0;

  task automatic chk(input string req, input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model();
    logic bad, sys, depl, unf;
    logic [XLEN-1:0] vt;
    bad  = req_class > 8;
    sys  = req_class == 6;
    depl = req_class == 3 && req_tin == 4;
    unf  = req_class == 3 && req_tin == 5;
    vt   = trap_base | ({28'd0, req_class} << 5);
    e_err = bad;
    if (bad) begin
      e_pc = req_pc;
      return;
    end
    e_pc = (req_class == 8) ? (irq_base | ((cur_irq_ctl & 32'h00FF0000) >> 10)) : vt;
    e_ret = depl ? vt : (sys ? req_next_pc : req_pc);
    e_id = {24'd0, req_tin};
    e_sp = cur_stat[9] ? cur_sp : int_sp;
    e_stat = {cur_stat[31:14], 2'b00, 2'b10, 1'b1, 1'b0, 1'b1, 7'd0};
    e_ic = cur_irq_ctl & ~32'h100;
    e_px = {cur_irq_ctl[7:0], cur_irq_ctl[8], cur_prev_ctx[22:0]};
    e_sc = cur_sys_ctl | (depl ? 32'h1 : 32'h0);
  endfunction

  task automatic do_trap(input int cls, input int tin, input bit stk, input int ack_dly);
    logic exp_save;
    @(negedge clk);
    req_class = CLS_W'(cls);
    req_tin = TIN_W'(tin);
    req_pc = $urandom & ~32'h3;
    req_next_pc = req_pc + 4;
    cur_stat = $urandom;
    cur_stat[9] = stk;
    cur_irq_ctl = $urandom;
    cur_prev_ctx = $urandom;
    cur_sp = $urandom;
    cur_sys_ctl = $urandom & ~32'h1;
    int_sp = $urandom;
    trap_base = $urandom & ~32'h1FF;
    irq_base = $urandom & ~32'h3FFF;
    req_valid = 1;
    exp_save = !(cls > 8 || cls == 6 || (cls == 3 && tin == 5));
    model();
    @(negedge clk);
    req_valid = 0;
    chk("R12", "ready low while busy", {31'd0, req_ready}, 0);
    chk("R10", "save_req", {31'd0, save_req}, {31'd0, exp_save});
    if (exp_save) begin
      for (int i = 0; i < ack_dly; i++) begin
        @(negedge clk);
        chk("R10", "save_req held", {31'd0, save_req}, 1);
        chk("R10", "no early done", {31'd0, done}, 0);
      end
      save_ack = 1;
      @(negedge clk);
      save_ack = 0;
    end else begin
      @(negedge clk);
    end
    chk("R12", "done", {31'd0, done}, 1);
    chk("R12", "ready during done", {31'd0, req_ready}, 0);
    chk("R11", "err", {31'd0, err}, {31'd0, e_err});
    chk(cls == 8 ? "R6" : (cls > 8 ? "R11" : "R5"), "new_pc", new_pc, e_pc);
    chk(cls == 6 ? "R8" : "R9", "ret_addr", ret_addr, e_ret);
    chk("R7", "id_out", id_out, e_id);
    chk("R1", "new_sp", new_sp, e_sp);
    chk("R3", "new_stat", new_stat, e_stat);
    chk("R4", "new_irq_ctl", new_irq_ctl, e_ic);
    chk("R4", "new_prev_ctx", new_prev_ctx, e_px);
    chk("R9", "new_sys_ctl", new_sys_ctl, e_sc);
    @(negedge clk);
    chk("R12", "done dropped", {31'd0, done}, 0);
    chk("R12", "ready back", {31'd0, req_ready}, 1);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "reset ready", {31'd0, req_ready}, 1);
    chk("R12", "reset done", {31'd0, done}, 0);
    chk("R12", "reset err", {31'd0, err}, 0);
    chk("R12", "reset save_req", {31'd0, save_req}, 0);
    chk("R12", "reset new_pc", new_pc, 0);
    chk("R12", "reset new_stat", new_stat, 0);
    rst_n = 1;
    // R11 straight after reset: other outputs stay at zero
    do_trap(9, 1, 0, 0);
    // directed corners
    do_trap(0, 0, 0, 0);      // R1 stack switch
    do_trap(1, 2, 1, 2);      // R1 stack kept
    do_trap(6, 3, 0, 0);      // R8 syscall return, R10 no save
    do_trap(3, 4, 0, 3);      // R9 depleted
    do_trap(3, 5, 1, 0);      // R10 underflow no save
    do_trap(8, 0, 0, 1);      // R6 interrupt vector
    do_trap(7, 0, 1, 0);      // R5 highest trap class
    do_trap(15, 7, 0, 0);     // R11 illegal class
    do_trap(2, 9, 0, 4);
    // random mix
    for (int n = 0; n < 300; n++) begin
      do_trap(int'($urandom % 11), int'($urandom % 8), bit'($urandom % 2), int'($urandom % 4));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule